// File: doc/BRIEF.md
# Dual-Channel Interrupt Vector and Pending Logic

This block collects the interrupt conditions of two serial channels, called A and B, and turns them into three things: a six-bit pending-flags word, an interrupt request with daisy-chain control, and an 8-bit interrupt vector. Each channel raises three kinds of request: receive (a character is available, or a special receive condition), transmit (the buffer is empty) and external/status (one or more enabled line or timer events). A per-channel enable register and a per-channel event mask decide which conditions count as pending. Two registers are shared by both channels: the stored vector and a master control register.

Software reads the vector back in two ways. The channel A view returns the stored byte unchanged. The channel B view always replaces a 3-bit field with a code for the highest pending source. On an acknowledge strobe the block places the highest eligible source under service and presents a vector, which may be modified in the same way. A command written to the command address takes the highest in-service source out of service.

Top module: `sio_irq_vector`

## Requirements
- R1: Pending flag bits are: bit 5 A receive, bit 4 A transmit, bit 3 A ext/status, bit 2 B receive, bit 1 B transmit, bit 0 B ext/status. Transmit is pending when the channel's transmit-empty input is high and bit 1 of its enable register (address 1) is set. Ext/status is pending when bit 0 of the enable register is set and any event input is high whose bit is set in the channel's event mask (address 15). Only mask bits 1, 3, 4, 5, 6 and 7 are meaningful.
- R2: Receive mode is bits 4:3 of the enable register. 00: receive never pending. 10: pending on character available or special condition. 11: pending on special condition only. 01: pending on a special condition, or on character available only while an arm flag is set; a write to the enable register sets the flag and acknowledging that channel's receive request clears it.
- R3: The channel B readback inserts the 3-bit code of the highest pending source. The codes are A special receive 111, A receive available 110, A ext/status 101, A transmit 100, B special receive 011, B receive available 010, B ext/status 001, B transmit 000. When nothing is pending the code is 011. This is independent of the include-status bit.
- R4: The vector register (address 2) is written from either channel, and the channel A readback returns it unmodified.
- R5: Master control bit 4 (address 9, shared) selects the code position. Clear places the code in vector bits 3:1, set places it in bits 6:4. All other bits come from the stored vector.
- R6: Priority from highest to lowest is pending-bit order 5 down to 0. A source is eligible if it is pending and no source of equal or higher priority is under service. int_req is high when master bit 3 is set, chain_en_in is high and any source is eligible.
- R7: When ack is high while int_req is high, the highest eligible source enters service at the clock edge. ack_drive is high in that cycle unless master bit 1 is set. ack_vector is the modified vector (as in R3 and R5, for the eligible source) when master bit 0 is set, otherwise the stored vector.
- R8: A write to address 0 with data bits 5:3 equal to 111, from either channel, takes the highest-priority in-service source out of service. If an acknowledge falls in the same cycle, the clear acts on the state before the edge and the acknowledged source still enters service.
- R9: chain_en_out is low when master bit 2 is set, when chain_en_in is low, when any source is in service or when int_req is high, and high otherwise.
- R10: Reset clears the enable, mask, vector and master registers, the arm flags and the in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_chan | input | 1 | Channel of the write: 0 A, 1 B |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| src_rx_avail | input | 2 | Receive character available, bit 0 A, bit 1 B |
| src_rx_special | input | 2 | Special receive condition, bit 0 A, bit 1 B |
| src_tx_empty | input | 2 | Transmit buffer empty, bit 0 A, bit 1 B |
| src_ext_a | input | 8 | Channel A external/status event lines |
| src_ext_b | input | 8 | Channel B external/status event lines |
| chain_en_in | input | 1 | Daisy-chain enable from the higher-priority device |
| ack | input | 1 | Interrupt acknowledge strobe |
| int_req | output | 1 | Interrupt request |
| chain_en_out | output | 1 | Daisy-chain enable to lower-priority devices |
| ack_drive | output | 1 | Vector is driven for this acknowledge |
| ack_vector | output | 8 | Vector presented during acknowledge |
| pend_flags | output | 6 | Pending flags of both channels |
| vec_rd_a | output | 8 | Vector as read through channel A |
| vec_rd_b | output | 8 | Vector as read through channel B |

## Verification
An acknowledge and a reset-under-service command can arrive in the same clock cycle, and both change the in-service state. The bench sets this up with channel A transmit under service and channel A receive newly pending. It then raises ack and writes the command in one cycle. The outcome is judged at the ports: int_req must stay low while the receive source remains in service, and after a single further command the transmit source must request again, which shows that the first clear removed the transmit source and the acknowledge added the receive source.

// File: rtl/sio_irq_pkg.sv
// Shared constants, register layout and source coding for the dual-channel
// interrupt vector logic. Assumes channel index 0 is A and 1 is B.
package sio_irq_pkg;
    localparam int NUM_CH      = 2;
    localparam int SRC_PER_CH  = 3;
    localparam int NUM_SRC     = NUM_CH * SRC_PER_CH;
    localparam int IDX_W       = $clog2(NUM_SRC);
    localparam int CODE_W      = 3;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 4;

    localparam logic [ADDR_W-1:0] ADDR_CMD    = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_CH_EN  = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_VEC    = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_MASTER = 4'd9;
    localparam logic [ADDR_W-1:0] ADDR_EXT_EN = 4'd15;

    localparam logic [2:0]        CMD_END_SVC = 3'b111;
    localparam logic [CODE_W-1:0] CODE_IDLE   = 3'b011;

    // Pending-bit positions of the two receive sources
    localparam logic [IDX_W-1:0] IDX_A_RX = IDX_W'(5);
    localparam logic [IDX_W-1:0] IDX_B_RX = IDX_W'(2);

    typedef struct packed {
        logic [2:0] spare;
        logic       stat_high;
        logic       mie;
        logic       chain_dis;
        logic       no_vec;
        logic       inc_stat;
    } master_t;

    // Status code of a pending-bit index; the receive codes depend on the special flag
    function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx,
                                                   input logic sp_a, input logic sp_b);
        case (idx)
            IDX_W'(5): src_code = {2'b11, sp_a};
            IDX_W'(4): src_code = 3'b100;
            IDX_W'(3): src_code = 3'b101;
            IDX_W'(2): src_code = {2'b01, sp_b};
            IDX_W'(1): src_code = 3'b000;
            default:   src_code = 3'b001;
        endcase
    endfunction
endpackage

// File: rtl/sio_irq_chan_src.sv
// One channel's request conditions: holds the channel enable and event-mask
// registers and the first-character arm flag, and reports receive, transmit
// and ext/status requests. Assumes write strobes are already decoded.
module sio_irq_chan_src #(
    parameter int          DATA_W    = 8,
    parameter logic [7:0]  EXT_VALID = 8'hFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_avail,
    input  logic              rx_special,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] ext_src,
    input  logic              rx_taken,
    output logic [2:0]        req
);
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] mask_q;
    logic              armed_q;
    logic [1:0]        rx_mode;
    logic              rx_p, tx_p, ext_p;

    // Register the enable and event-mask values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
        end else begin
            if (en_we)   en_q   <= wdata;
            if (mask_we) mask_q <= wdata & EXT_VALID;
        end
    end

    // Arm on enable write, disarm once the receive request is acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n)        armed_q <= 1'b0;
        else if (en_we)    armed_q <= 1'b1;
        else if (rx_taken) armed_q <= 1'b0;
    end

    // Derive the three request conditions from the enables
    always_comb begin
        rx_mode = en_q[4:3];
        case (rx_mode)
            2'b01:   rx_p = rx_special | (rx_avail & armed_q);
            2'b10:   rx_p = rx_special | rx_avail;
            2'b11:   rx_p = rx_special;
            default: rx_p = 1'b0;
        endcase
        tx_p  = tx_empty & en_q[1];
        ext_p = en_q[0] & (|(ext_src & mask_q));
        req   = {rx_p, tx_p, ext_p};
    end

    // R2: once the first-character request is taken, it does not come back without a new write
    assert_first_disarm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_taken && !en_we && rx_mode == 2'b01) |=> (!req[2] || rx_special || en_we || $past(en_we)));
endmodule

// File: rtl/sio_irq_prio.sv
// Priority and in-service tracking: finds the highest pending and highest
// eligible source, raises the request, and updates the in-service flags on
// acknowledge and on the end-of-service command. Higher index = higher priority.
module sio_irq_prio #(
    parameter int NUM_SRC = 6,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic               mie,
    input  logic               chain_in,
    input  logic               ack,
    input  logic               end_svc,
    output logic               int_req,
    output logic               ack_fire,
    output logic               any_svc,
    output logic [IDX_W-1:0]   sel_idx,
    output logic               sel_valid,
    output logic [IDX_W-1:0]   top_idx,
    output logic               top_valid
);
    logic [NUM_SRC-1:0] ius_q;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] set_mask;
    logic               blk;

    // Eligibility: pending and not masked by an equal or higher in-service source
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            blk = 1'b0;
            for (int j = 0; j < NUM_SRC; j++)
                if (j >= i) blk = blk | ius_q[j];
            elig[i] = pend[i] & ~blk;
        end
    end

    // Priority encoders for eligible, pending and in-service sets
    always_comb begin
        sel_idx   = '0;
        sel_valid = 1'b0;
        top_idx   = '0;
        top_valid = 1'b0;
        clr_mask  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i]) begin
                sel_idx   = IDX_W'(i);
                sel_valid = 1'b1;
            end
            if (pend[i]) begin
                top_idx   = IDX_W'(i);
                top_valid = 1'b1;
            end
            if (ius_q[i]) begin
                clr_mask    = '0;
                clr_mask[i] = 1'b1;
            end
        end
    end

    // Request, acknowledge and set mask
    always_comb begin
        int_req  = mie & chain_in & sel_valid;
        ack_fire = ack & int_req;
        set_mask = '0;
        if (ack_fire) set_mask[sel_idx] = 1'b1;
        any_svc  = |ius_q;
    end

    // In-service state: clear from the pre-edge state, then add the acknowledged source
    always_ff @(posedge clk) begin
        if (!rst_n) ius_q <= '0;
        else        ius_q <= (ius_q & ~(end_svc ? clr_mask : '0)) | set_mask;
    end

    // R7: an acknowledge alone adds exactly one in-service source
    assert_ack_adds_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !end_svc) |=> ($countones(ius_q) == $past($countones(ius_q)) + 1));
    // R8: the end-of-service command alone removes exactly one source
    assert_end_svc_removes_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_svc && !ack_fire && any_svc) |=> ($countones(ius_q) == $past($countones(ius_q)) - 1));
    // R8: without acknowledge or command the in-service state holds
    assert_svc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_fire && !end_svc) |=> $stable(ius_q));
endmodule

// File: rtl/sio_irq_vec_fmt.sv
// Vector formatter: places the 3-bit status code of a source into either
// bits 3:1 or bits 6:4 of the stored vector. No source gives the idle code.
module sio_irq_vec_fmt
    import sio_irq_pkg::*;
(
    input  logic [DATA_W-1:0] base,
    input  logic              valid,
    input  logic [IDX_W-1:0]  idx,
    input  logic              sp_a,
    input  logic              sp_b,
    input  logic              stat_high,
    output logic [DATA_W-1:0] vec
);
    logic [CODE_W-1:0] code;

    // Choose the code and splice it into the selected field
    always_comb begin
        code = valid ? src_code(idx, sp_a, sp_b) : CODE_IDLE;
        if (stat_high) vec = {base[7], code, base[3:0]};
        else           vec = {base[7:4], code, base[0]};
    end
endmodule

// File: rtl/sio_irq_vector.sv
// Top of the dual-channel interrupt vector logic: decodes register writes,
// holds the shared vector and master control registers, instantiates one
// request block per channel, the priority tracker and two vector formatters.
// Assumes sources are synchronous to clk.
module sio_irq_vector
    import sio_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic                  reg_chan,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic [NUM_CH-1:0]     src_rx_avail,
    input  logic [NUM_CH-1:0]     src_rx_special,
    input  logic [NUM_CH-1:0]     src_tx_empty,
    input  logic [DATA_W-1:0]     src_ext_a,
    input  logic [DATA_W-1:0]     src_ext_b,
    input  logic                  chain_en_in,
    input  logic                  ack,
    output logic                  int_req,
    output logic                  chain_en_out,
    output logic                  ack_drive,
    output logic [DATA_W-1:0]     ack_vector,
    output logic [NUM_SRC-1:0]    pend_flags,
    output logic [DATA_W-1:0]     vec_rd_a,
    output logic [DATA_W-1:0]     vec_rd_b
);
    logic [DATA_W-1:0] vec_q;
    master_t           mst_q;
    logic              end_svc;
    logic              ack_fire, any_svc, sel_valid, top_valid;
    logic [IDX_W-1:0]  sel_idx, top_idx;
    logic [NUM_CH-1:0] rx_taken;
    logic [DATA_W-1:0] ext_arr [NUM_CH];
    logic [DATA_W-1:0] ack_mod;

    // Command decode: end-of-service from either channel
    always_comb begin
        end_svc     = reg_we && reg_addr == ADDR_CMD && reg_wdata[5:3] == CMD_END_SVC;
        ext_arr[0]  = src_ext_a;
        ext_arr[1]  = src_ext_b;
        rx_taken[0] = ack_fire && sel_idx == IDX_A_RX;
        rx_taken[1] = ack_fire && sel_idx == IDX_B_RX;
    end

    // Shared registers, writable through either channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            mst_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_VEC)    vec_q <= reg_wdata;
            if (reg_addr == ADDR_MASTER) mst_q <= master_t'(reg_wdata);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        localparam int BASE = SRC_PER_CH * (NUM_CH - 1 - c);
        logic en_we, mask_we;
        assign en_we   = reg_we && reg_chan == c[0] && reg_addr == ADDR_CH_EN;
        assign mask_we = reg_we && reg_chan == c[0] && reg_addr == ADDR_EXT_EN;
        sio_irq_chan_src #(.DATA_W(DATA_W)) i_src (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_we      (en_we),
            .mask_we    (mask_we),
            .wdata      (reg_wdata),
            .rx_avail   (src_rx_avail[c]),
            .rx_special (src_rx_special[c]),
            .tx_empty   (src_tx_empty[c]),
            .ext_src    (ext_arr[c]),
            .rx_taken   (rx_taken[c]),
            .req        (pend_flags[BASE +: SRC_PER_CH])
        );
    end

    sio_irq_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend_flags),
        .mie       (mst_q.mie),
        .chain_in  (chain_en_in),
        .ack       (ack),
        .end_svc   (end_svc),
        .int_req   (int_req),
        .ack_fire  (ack_fire),
        .any_svc   (any_svc),
        .sel_idx   (sel_idx),
        .sel_valid (sel_valid),
        .top_idx   (top_idx),
        .top_valid (top_valid)
    );

    sio_irq_vec_fmt i_fmt_rd (
        .base      (vec_q),
        .valid     (top_valid),
        .idx       (top_idx),
        .sp_a      (src_rx_special[0]),
        .sp_b      (src_rx_special[1]),
        .stat_high (mst_q.stat_high),
        .vec       (vec_rd_b)
    );

    sio_irq_vec_fmt i_fmt_ack (
        .base      (vec_q),
        .valid     (sel_valid),
        .idx       (sel_idx),
        .sp_a      (src_rx_special[0]),
        .sp_b      (src_rx_special[1]),
        .stat_high (mst_q.stat_high),
        .vec       (ack_mod)
    );

    // Outputs toward the bus and the daisy chain
    always_comb begin
        vec_rd_a     = vec_q;
        ack_vector   = mst_q.inc_stat ? ack_mod : vec_q;
        ack_drive    = ack_fire & ~mst_q.no_vec;
        chain_en_out = chain_en_in & ~mst_q.chain_dis & ~any_svc & ~int_req;
    end

    // R3: with nothing pending the channel B readback carries the idle code
    assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_flags == '0) |-> (mst_q.stat_high ? vec_rd_b[6:4] == CODE_IDLE : vec_rd_b[3:1] == CODE_IDLE));
    // R6: a request always has a pending source behind it
    assert_req_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (pend_flags != '0));
    // R9: a request blocks lower devices on the chain
    assert_req_blocks_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> !chain_en_out);
endmodule

// File: tb/test_sio_irq_vector.sv
module test_sio_irq_vector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0, reg_chan = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [1:0] rx_av = '0, rx_sp = '0, tx_em = '0;
    logic [7:0] ext_a = '0, ext_b = '0;
    logic       chain_in = 1'b1, ack = 1'b0;
    logic       int_req, chain_out, ack_drive;
    logic [7:0] ack_vector, vec_a, vec_b;
    logic [5:0] pend;
    int         n_chk = 0, n_fail = 0, cyc = 0;

    sio_irq_vector i_sio_irq_vector (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_chan(reg_chan),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .src_rx_avail(rx_av),
        .src_rx_special(rx_sp), .src_tx_empty(tx_em), .src_ext_a(ext_a),
        .src_ext_b(ext_b), .chain_en_in(chain_in), .ack(ack), .int_req(int_req),
        .chain_en_out(chain_out), .ack_drive(ack_drive), .ack_vector(ack_vector),
        .pend_flags(pend), .vec_rd_a(vec_a), .vec_rd_b(vec_b)
    );

    always #10 clk = ~clk;

    // {rxA spA txA cdA rxB spB txB cdB, expected pend[5:0], expected channel B vector}
    localparam logic [21:0] TBL [12] = '{
        {8'h00, 6'h00, 8'h56}, {8'h02, 6'h02, 8'h50}, {8'h01, 6'h01, 8'h52},
        {8'h08, 6'h04, 8'h54}, {8'h0C, 6'h04, 8'h56}, {8'h20, 6'h10, 8'h58},
        {8'h10, 6'h08, 8'h5A}, {8'h80, 6'h20, 8'h5C}, {8'hC0, 6'h20, 8'h5E},
        {8'hBB, 6'h3F, 8'h5C}, {8'h29, 6'h15, 8'h58}, {8'h12, 6'h0A, 8'h5A}
    };

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wreg(input logic ch, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_chan = ch; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        #5;
    endtask

    task automatic do_ack(input string req, input logic exp_drive, input logic [7:0] exp_vec, input logic chk_vec);
        @(negedge clk);
        ack = 1'b1;
        #5;
        chk(req, "ack_drive", {7'd0, ack_drive}, {7'd0, exp_drive});
        if (chk_vec) chk(req, "ack_vector", ack_vector, exp_vec);
        @(negedge clk);
        ack = 1'b0;
        #5;
    endtask

    task automatic settle;
        @(negedge clk);
        #5;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R10 reset state
        chk("R10", "pend", {2'b0, pend}, 8'h00);
        chk("R10", "int_req", {7'd0, int_req}, 8'h00);
        chk("R10", "vec_a", vec_a, 8'h00);
        chk("R3", "vec_b idle after reset", vec_b, 8'h06);
        chk("R9", "chain_out after reset", {7'd0, chain_out}, 8'h01);

        // Configuration; vector written through channel B
        wreg(1'b1, 4'd2, 8'h50);
        chk("R4", "vec_a after write from B", vec_a, 8'h50);
        wreg(1'b0, 4'd1, 8'h13);
        wreg(1'b1, 4'd1, 8'h13);
        wreg(1'b0, 4'd15, 8'h08);
        wreg(1'b1, 4'd15, 8'h08);
        wreg(1'b0, 4'd9, 8'h08);

        // Table walk: R1 flags, R3 codes, R6 request
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            rx_av = {TBL[k][17], TBL[k][21]};
            rx_sp = {TBL[k][16], TBL[k][20]};
            tx_em = {TBL[k][15], TBL[k][19]};
            ext_a = {4'd0, TBL[k][18], 3'd0};
            ext_b = {4'd0, TBL[k][14], 3'd0};
            #5;
            chk("R1", "pend", {2'b0, pend}, {2'b0, TBL[k][13:8]});
            chk("R3", "vec_b", vec_b, TBL[k][7:0]);
            chk("R6", "int_req", {7'd0, int_req}, {7'd0, TBL[k][13:8] != 6'd0});
            chk("R4", "vec_a", vec_a, 8'h50);
        end
        @(negedge clk);
        rx_av = '0; rx_sp = '0; tx_em = '0; ext_a = '0; ext_b = '0;

        // R5 code in bits 6:4
        wreg(1'b0, 4'd9, 8'h18);
        @(negedge clk); tx_em[0] = 1'b1; #5;
        chk("R5", "vec_b high field", vec_b, 8'h40);
        chk("R4", "vec_a unmodified", vec_a, 8'h50);

        // R6 master enable and chain input; R9 chain output
        wreg(1'b0, 4'd9, 8'h00);
        chk("R6", "int_req master off", {7'd0, int_req}, 8'h00);
        chk("R1", "pend master off", {2'b0, pend}, 8'h10);
        wreg(1'b0, 4'd9, 8'h08);
        @(negedge clk); chain_in = 1'b0; #5;
        chk("R6", "int_req chain in low", {7'd0, int_req}, 8'h00);
        chk("R9", "chain_out chain in low", {7'd0, chain_out}, 8'h00);
        @(negedge clk); chain_in = 1'b1; #5;
        chk("R6", "int_req chain in high", {7'd0, int_req}, 8'h01);
        chk("R9", "chain_out while requesting", {7'd0, chain_out}, 8'h00);
        @(negedge clk); tx_em[0] = 1'b0; #5;
        chk("R9", "chain_out idle", {7'd0, chain_out}, 8'h01);
        wreg(1'b0, 4'd9, 8'h0C);
        chk("R9", "chain_out disabled", {7'd0, chain_out}, 8'h00);

        // R7 acknowledge with status included
        wreg(1'b0, 4'd9, 8'h09);
        @(negedge clk); tx_em[0] = 1'b1; rx_av[1] = 1'b1; #5;
        do_ack("R7", 1'b1, 8'h58, 1'b1);
        chk("R6", "int_req blocked by A tx in service", {7'd0, int_req}, 8'h00);
        chk("R9", "chain_out in service", {7'd0, chain_out}, 8'h00);
        @(negedge clk); rx_av[0] = 1'b1; #5;
        chk("R6", "higher source requests", {7'd0, int_req}, 8'h01);
        do_ack("R7", 1'b1, 8'h5C, 1'b1);
        @(negedge clk); rx_av[0] = 1'b0; #5;
        chk("R6", "both A in service", {7'd0, int_req}, 8'h00);
        wreg(1'b0, 4'd0, 8'h38);
        chk("R8", "first end clears A rx only", {7'd0, int_req}, 8'h00);
        wreg(1'b1, 4'd0, 8'h38);
        chk("R8", "second end frees A tx", {7'd0, int_req}, 8'h01);

        // R8 acknowledge and end-of-service in the same cycle
        do_ack("R7", 1'b1, 8'h58, 1'b1);
        @(negedge clk); rx_av[0] = 1'b1; #5;
        @(negedge clk);
        ack = 1'b1; reg_we = 1'b1; reg_chan = 1'b0; reg_addr = 4'd0; reg_wdata = 8'h38;
        @(negedge clk);
        ack = 1'b0; reg_we = 1'b0; rx_av[0] = 1'b0;
        #5;
        chk("R8", "A rx in service after same cycle", {7'd0, int_req}, 8'h00);
        wreg(1'b0, 4'd0, 8'h38);
        chk("R8", "A tx was cleared in same cycle", {7'd0, int_req}, 8'h01);

        // R7 no-vector option still takes service
        wreg(1'b0, 4'd9, 8'h0B);
        do_ack("R7", 1'b0, 8'h00, 1'b0);
        chk("R7", "no-vector ack still in service", {7'd0, int_req}, 8'h00);
        wreg(1'b0, 4'd0, 8'h38);

        // R7 status not included
        wreg(1'b0, 4'd9, 8'h08);
        do_ack("R7", 1'b1, 8'h50, 1'b1);
        wreg(1'b0, 4'd0, 8'h38);
        @(negedge clk); tx_em = '0; rx_av = '0; #5;
        chk("R6", "idle after cleanup", {7'd0, int_req}, 8'h00);

        // R2 special-only mode
        wreg(1'b1, 4'd1, 8'h1B);
        @(negedge clk); rx_av[1] = 1'b1; #5;
        chk("R2", "special-only ignores available", {2'b0, pend}, 8'h00);
        @(negedge clk); rx_sp[1] = 1'b1; #5;
        chk("R2", "special-only on special", {2'b0, pend}, 8'h04);
        @(negedge clk); rx_sp[1] = 1'b0; rx_av[1] = 1'b0; #5;

        // R2 first-character mode
        wreg(1'b1, 4'd1, 8'h0B);
        @(negedge clk); rx_av[1] = 1'b1; #5;
        chk("R2", "first char armed", {2'b0, pend}, 8'h04);
        do_ack("R2", 1'b1, 8'h00, 1'b0);
        wreg(1'b0, 4'd0, 8'h38);
        chk("R2", "first char disarmed after ack", {2'b0, pend}, 8'h00);
        wreg(1'b1, 4'd1, 8'h0B);
        chk("R2", "first char rearmed by write", {2'b0, pend}, 8'h04);
        @(negedge clk); rx_av[1] = 1'b0; #5;

        // R1 event mask and enables
        @(negedge clk); ext_a = 8'h20; #5;
        chk("R1", "unmasked event ignored", {2'b0, pend}, 8'h00);
        wreg(1'b0, 4'd15, 8'h20);
        chk("R1", "masked event pending", {2'b0, pend}, 8'h08);
        wreg(1'b0, 4'd1, 8'h12);
        chk("R1", "ext master enable off", {2'b0, pend}, 8'h00);
        @(negedge clk); tx_em[0] = 1'b1; #5;
        chk("R1", "tx enable on", {2'b0, pend}, 8'h10);
        wreg(1'b0, 4'd1, 8'h10);
        chk("R1", "tx enable off", {2'b0, pend}, 8'h00);
        @(negedge clk); tx_em = '0; ext_a = '0;

        // R10 reset again
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk("R10", "vec_a after second reset", vec_a, 8'h00);
        chk("R10", "pend after second reset", {2'b0, pend}, 8'h00);
        finish_run();
    end
endmodule